// File: doc/BRIEF.md
# Accumulator ALU with Flag Update Mask

This block is the arithmetic and logic datapath of a small accumulator machine. Each operation takes the accumulator, one 8-bit operand and the current flag nibble. It returns a result byte, a fresh value for each of the four flags (zero, subtract, half-carry, carry) and a mask that says which flags the operation really writes. The caller merges the new flags into the flag register under that mask. A separate strobe says whether the result belongs in the accumulator.

The computing part, `alu8_core`, is purely combinational. The top module wraps it in one register stage. When `op_vld` is high, that stage captures the result, the merged flags, the mask and the accumulator strobe. This gives a bench or a pipeline a clean one-cycle view of every operation. Operation codes and the flag bit order are fixed by this brief.

The flag nibble is ordered {zero, subtract, half-carry, carry} on bits 3..0. Operation codes (4 bits) are:

| Code | Operation |
|---|---|
| 0 | add |
| 1 | add with carry |
| 2 | subtract |
| 3 | subtract with borrow |
| 4 | AND |
| 5 | XOR |
| 6 | OR |
| 7 | compare |
| 8 | increment |
| 9 | decrement |
| 10 | complement |
| 11 | decimal adjust |
| 12..15 | unused |

Top module: `alu8_flags_top`

## Requirements
- R1: Code 0 returns A+B and code 1 returns A+B+carry_in. Both clear subtract and write zero, half-carry and carry. Half-carry is the carry out of bit 3 and carry is the carry out of bit 7, with carry_in counted in both.
- R2: Code 2 returns A−B and code 3 returns A−B−carry_in. Both set subtract. Half-carry is a borrow into the low nibble and carry is a borrow out of the byte, with carry_in counted in both.
- R3: Code 7 (compare) writes all four flags exactly as code 2 would. It leaves the result equal to A and drives the accumulator strobe low.
- R4: Code 4 (AND) gives flags {z,0,1,0}. Codes 5 (XOR) and 6 (OR) give {z,0,0,0}.
- R5: Code 8 (increment) and code 9 (decrement) return A+1 and A−1. Subtract is cleared for increment and set for decrement. Zero and half-carry are computed, and carry is not written (mask 4'b1110).
- R6: Code 10 returns A XOR 0xFF and forces subtract and half-carry to 1. Zero and carry are not written (mask 4'b0110).
- R7: Code 11 with subtract clear corrects after an add. It adds 0x06 if half-carry is set or the low nibble exceeds 9. It adds 0x60 and sets carry if carry is set or A exceeds 0x99; otherwise carry is cleared.
- R8: Code 11 with subtract set corrects after a subtract. It takes away 0x06 if half-carry is set and 0x60 if carry is set, and carry keeps its value. For both directions of the adjust, half-carry is cleared, subtract is not written (mask 4'b1011), and zero is computed.
- R9: When the zero flag is written, it is 1 exactly when the 8-bit result (for compare, the difference) is 0x00.
- R10: Codes 12 to 15 return A, write no flag (mask 0) and drive the accumulator strobe low.
- R11: Outputs appear one clock after an `op_vld` cycle, with `out_vld` high for that cycle. After reset, every output is zero.
- R12: Each bit of `flags_o` whose mask bit is 0 equals the matching bit of `flags_i` captured with the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_vld | input | 1 | Capture this cycle's operation |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand |
| flags_i | input | 4 | Current flags {z,n,h,c} |
| out_vld | output | 1 | Registered outputs are fresh |
| res_o | output | 8 | Result byte |
| flags_o | output | 4 | Flags after the mask merge |
| fwe_o | output | 4 | Per-flag write mask {z,n,h,c} |
| acc_we_o | output | 1 | Result should be written to the accumulator |

## Verification
The bench targets nibble boundaries. Examples are 0x0F+1 and 0x10−1, a borrow right through 0x00−1, and an add-with-carry where only the incoming carry crosses bit 3. A design that took half-carry from the wrong bit, or left carry_in out of the nibble sum, would show the wrong h bit on these vectors.

Increment, decrement, complement and decimal adjust are applied with opposite values on the flags they must not write. A design that drops the mask, or writes carry on increment, shows a flipped bit. Decimal adjust is driven in both the add and subtract directions, including the 0x9A wrap to 0x00 with carry. Compare with equal operands must give zero set while the result stays at A and the accumulator strobe stays low.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_ADC = 4'd1,
      OP_SUB = 4'd2,
      OP_SBC = 4'd3,
      OP_AND = 4'd4,
      OP_XOR = 4'd5,
      OP_OR  = 4'd6,
      OP_CP  = 4'd7,
      OP_INC = 4'd8,
      OP_DEC = 4'd9,
      OP_CPL = 4'd10,
      OP_DAA = 4'd11
   } alu_op_e;

   // flag nibble bit positions {z,n,h,c}
   localparam int FZ = 3;
   localparam int FN = 2;
   localparam int FH = 1;
   localparam int FC = 0;

   typedef enum logic [1:0] {
      LG_AND = 2'd0,
      LG_XOR = 2'd1,
      LG_OR  = 2'd2,
      LG_INV = 2'd3
   } logic_sel_e;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
   parameter int DATA_W = 8,
   parameter int NIB_W  = 4
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              cin_i,
   input  logic              sub_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              half_o,
   output logic              cout_o
);
   localparam int LO_W = NIB_W + 1;
   localparam int FW_W = DATA_W + 1;

   if (NIB_W < 1 || NIB_W >= DATA_W) begin : g_bad_nib
      $error("alu8_addsub: NIB_W must lie between 1 and DATA_W-1");
   end

   logic [LO_W-1:0] lo_a, lo_b, lo_c, lo_r;
   logic [FW_W-1:0] fw_a, fw_b, fw_c, fw_r;

   always_comb begin
      lo_a = {1'b0, a_i[NIB_W-1:0]};
      lo_b = {1'b0, b_i[NIB_W-1:0]};
      lo_c = {{NIB_W{1'b0}}, cin_i};
      fw_a = {1'b0, a_i};
      fw_b = {1'b0, b_i};
      fw_c = {{DATA_W{1'b0}}, cin_i};
      if (sub_i) begin
         lo_r = lo_a - lo_b - lo_c;
         fw_r = fw_a - fw_b - fw_c;
      end else begin
         lo_r = lo_a + lo_b + lo_c;
         fw_r = fw_a + fw_b + fw_c;
      end
      sum_o  = fw_r[DATA_W-1:0];
      half_o = lo_r[NIB_W];
      cout_o = fw_r[DATA_W];
   end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0]   a_i,
   input  logic [DATA_W-1:0]   b_i,
   input  alu8_pkg::logic_sel_e sel_i,
   output logic [DATA_W-1:0]   y_o
);
   import alu8_pkg::*;

   always_comb begin
      unique case (sel_i)
         LG_AND:  y_o = a_i & b_i;
         LG_XOR:  y_o = a_i ^ b_i;
         LG_OR:   y_o = a_i | b_i;
         default: y_o = ~a_i;
      endcase
   end

endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj #(
   parameter int DATA_W = 8,
   parameter bit ENABLE = 1'b1
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic              n_i,
   input  logic              h_i,
   input  logic              c_i,
   output logic [DATA_W-1:0] y_o,
   output logic              c_o
);
   if (ENABLE) begin : g_adj
      if (DATA_W != 8) begin : g_bad_w
         $error("alu8_decadj: decimal adjust needs DATA_W of 8");
      end
      localparam logic [DATA_W-1:0] LO_FIX = DATA_W'(8'h06);
      localparam logic [DATA_W-1:0] HI_FIX = DATA_W'(8'h60);
      localparam logic [DATA_W-1:0] HI_LIM = DATA_W'(8'h99);
      localparam logic [3:0]        NIB_LIM = 4'd9;

      logic [DATA_W-1:0] fix;
      logic              carry_nxt;

      always_comb begin
         fix       = '0;
         carry_nxt = c_i;
         if (!n_i) begin
            if (h_i || (a_i[3:0] > NIB_LIM)) fix = fix | LO_FIX;
            if (c_i || (a_i > HI_LIM)) begin
               fix       = fix | HI_FIX;
               carry_nxt = 1'b1;
            end else begin
               carry_nxt = 1'b0;
            end
            y_o = a_i + fix;
         end else begin
            if (h_i) fix = fix | LO_FIX;
            if (c_i) fix = fix | HI_FIX;
            y_o = a_i - fix;
         end
         c_o = carry_nxt;
      end
   end else begin : g_pass
      assign y_o = a_i;
      assign c_o = c_i;
   end

endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
   parameter int DATA_W = 8,
   parameter int NIB_W  = 4,
   parameter bit DAA_EN = 1'b1
) (
   input  logic [3:0]        op_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  logic [3:0]        flags_i,
   output logic [DATA_W-1:0] res_o,
   output logic [3:0]        fnew_o,
   output logic [3:0]        fwe_o,
   output logic              acc_we_o
);
   import alu8_pkg::*;

   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   alu_op_e           op;
   logic [DATA_W-1:0] as_b, as_sum, lg_y, da_y;
   logic              as_cin, as_sub, as_h, as_c, da_c;
   logic_sel_e        lg_sel;

   assign op = alu_op_e'(op_i);

   always_comb begin
      as_b   = ((op == OP_INC) || (op == OP_DEC)) ? ONE : opnd_i;
      as_cin = ((op == OP_ADC) || (op == OP_SBC)) ? flags_i[FC] : 1'b0;
      as_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CP) || (op == OP_DEC);
      unique case (op)
         OP_AND:  lg_sel = LG_AND;
         OP_XOR:  lg_sel = LG_XOR;
         OP_OR:   lg_sel = LG_OR;
         default: lg_sel = LG_INV;
      endcase
   end

   alu8_addsub #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_addsub (
      .a_i(acc_i), .b_i(as_b), .cin_i(as_cin), .sub_i(as_sub),
      .sum_o(as_sum), .half_o(as_h), .cout_o(as_c)
   );

   alu8_logic #(.DATA_W(DATA_W)) u_logic (
      .a_i(acc_i), .b_i(opnd_i), .sel_i(lg_sel), .y_o(lg_y)
   );

   alu8_decadj #(.DATA_W(DATA_W), .ENABLE(DAA_EN)) u_decadj (
      .a_i(acc_i), .n_i(flags_i[FN]), .h_i(flags_i[FH]), .c_i(flags_i[FC]),
      .y_o(da_y), .c_o(da_c)
   );

   always_comb begin
      res_o    = acc_i;
      fnew_o   = flags_i;
      fwe_o    = 4'b0000;
      acc_we_o = 1'b0;
      case (op)
         OP_ADD, OP_ADC: begin
            res_o    = as_sum;
            fnew_o   = {as_sum == '0, 1'b0, as_h, as_c};
            fwe_o    = 4'b1111;
            acc_we_o = 1'b1;
         end
         OP_SUB, OP_SBC: begin
            res_o    = as_sum;
            fnew_o   = {as_sum == '0, 1'b1, as_h, as_c};
            fwe_o    = 4'b1111;
            acc_we_o = 1'b1;
         end
         OP_CP: begin
            fnew_o   = {as_sum == '0, 1'b1, as_h, as_c};
            fwe_o    = 4'b1111;
         end
         OP_AND: begin
            res_o    = lg_y;
            fnew_o   = {lg_y == '0, 3'b010};
            fwe_o    = 4'b1111;
            acc_we_o = 1'b1;
         end
         OP_XOR, OP_OR: begin
            res_o    = lg_y;
            fnew_o   = {lg_y == '0, 3'b000};
            fwe_o    = 4'b1111;
            acc_we_o = 1'b1;
         end
         OP_INC, OP_DEC: begin
            res_o    = as_sum;
            fnew_o   = {as_sum == '0, as_sub, as_h, flags_i[FC]};
            fwe_o    = 4'b1110;
            acc_we_o = 1'b1;
         end
         OP_CPL: begin
            res_o    = lg_y;
            fnew_o   = {flags_i[FZ], 2'b11, flags_i[FC]};
            fwe_o    = 4'b0110;
            acc_we_o = 1'b1;
         end
         OP_DAA: begin
            if (DAA_EN) begin
               res_o    = da_y;
               fnew_o   = {da_y == '0, flags_i[FN], 1'b0, da_c};
               fwe_o    = 4'b1011;
               acc_we_o = 1'b1;
            end
         end
         default: ;
      endcase
   end

   always_comb begin
      // R1 addition never reports the subtract flag set while writing it
      if ((op == OP_ADD || op == OP_ADC) && fwe_o[FN])
         add_n_clear_chk: assert (!fnew_o[FN]);
   end

endmodule

// File: rtl/alu8_flags_top.sv
module alu8_flags_top #(
   parameter int DATA_W = 8,
   parameter int NIB_W  = 4,
   parameter bit DAA_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_vld,
   input  logic [3:0]        op_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  logic [3:0]        flags_i,
   output logic              out_vld,
   output logic [DATA_W-1:0] res_o,
   output logic [3:0]        flags_o,
   output logic [3:0]        fwe_o,
   output logic              acc_we_o
);
   import alu8_pkg::*;

   if (DATA_W < 2) begin : g_bad_w
      $error("alu8_flags_top: DATA_W too small");
   end

   logic [DATA_W-1:0] c_res;
   logic [3:0]        c_fnew, c_fwe, c_merged;
   logic              c_accwe;

   alu8_core #(.DATA_W(DATA_W), .NIB_W(NIB_W), .DAA_EN(DAA_EN)) u_core (
      .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i), .flags_i(flags_i),
      .res_o(c_res), .fnew_o(c_fnew), .fwe_o(c_fwe), .acc_we_o(c_accwe)
   );

   for (genvar i = 0; i < 4; i++) begin : g_merge
      assign c_merged[i] = c_fwe[i] ? c_fnew[i] : flags_i[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         res_o    <= '0;
         flags_o  <= '0;
         fwe_o    <= '0;
         acc_we_o <= 1'b0;
      end else begin
         out_vld <= op_vld;
         if (op_vld) begin
            res_o    <= c_res;
            flags_o  <= c_merged;
            fwe_o    <= c_fwe;
            acc_we_o <= c_accwe;
         end
      end
   end

   // R12
   keep_unwritten_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> ((flags_o ^ $past(flags_i)) & ~fwe_o) == 4'b0000);

   // R3
   cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld && ($past(op_i) == 4'(OP_CP)) |-> !acc_we_o && (res_o == $past(acc_i)));

   // R9
   zero_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld && fwe_o[FZ] && acc_we_o |-> flags_o[FZ] == (res_o == '0));

   // R4
   and_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld && ($past(op_i) == 4'(OP_AND)) |-> flags_o[2:0] == 3'b010);

   // R5
   incdec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld && (($past(op_i) == 4'(OP_INC)) || ($past(op_i) == 4'(OP_DEC)))
      |-> flags_o[FC] == $past(flags_i[FC]));

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_vld && $past(rst_n) |=> $stable(res_o) || out_vld);

endmodule

// File: tb/alu8_flags_top_test.sv
module alu8_flags_top_test;

   localparam logic [3:0] ADD = 4'd0, ADC = 4'd1, SUB = 4'd2, SBC = 4'd3,
                          AND = 4'd4, XOR = 4'd5, OR = 4'd6, CP = 4'd7,
                          INC = 4'd8, DEC = 4'd9, CPL = 4'd10, DAA = 4'd11;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_vld = 1'b0;
   logic [3:0] op_i = '0;
   logic [7:0] acc_i = '0, opnd_i = '0;
   logic [3:0] flags_i = '0;
   logic       out_vld, acc_we_o;
   logic [7:0] res_o;
   logic [3:0] flags_o, fwe_o;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   alu8_flags_top uut (
      .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_i(op_i),
      .acc_i(acc_i), .opnd_i(opnd_i), .flags_i(flags_i),
      .out_vld(out_vld), .res_o(res_o), .flags_o(flags_o),
      .fwe_o(fwe_o), .acc_we_o(acc_we_o)
   );

   // independent reference for add/sub family, from R1 and R2
   function automatic void ref_addsub(input bit sub, input logic [7:0] a,
         input logic [7:0] b, input bit ci, output logic [7:0] r, output logic [3:0] f);
      int full, lo;
      if (sub) begin
         full = int'(a) - int'(b) - int'(ci);
         lo   = int'(a[3:0]) - int'(b[3:0]) - int'(ci);
      end else begin
         full = int'(a) + int'(b) + int'(ci);
         lo   = int'(a[3:0]) + int'(b[3:0]) + int'(ci);
      end
      r = 8'(full);
      f = {r == 8'h00, sub, (lo < 0) || (lo > 15), (full < 0) || (full > 255)};
   endfunction

   task automatic apply(input string tag, input logic [3:0] op, input logic [7:0] a,
         input logic [7:0] b, input logic [3:0] fin, input logic [7:0] e_res,
         input logic [3:0] e_flg, input logic [3:0] e_we, input logic e_acc);
      @(negedge clk);
      op_i = op; acc_i = a; opnd_i = b; flags_i = fin; op_vld = 1'b1;
      @(negedge clk);
      op_vld = 1'b0;
      n_vec++;
      if (!out_vld || res_o !== e_res || flags_o !== e_flg || fwe_o !== e_we
          || acc_we_o !== e_acc) begin
         n_bad++;
         $display("FAIL %s op=%0d a=%h b=%h: got vld=%b res=%h flg=%b we=%b acc=%b, want vld=1 res=%h flg=%b we=%b acc=%b",
                  tag, op, a, b, out_vld, res_o, flags_o, fwe_o, acc_we_o,
                  e_res, e_flg, e_we, e_acc);
      end
   endtask

   task automatic t_reset;
      n_vec++;
      if (out_vld !== 1'b0 || res_o !== 8'h00 || flags_o !== 4'h0 || fwe_o !== 4'h0
          || acc_we_o !== 1'b0) begin
         n_bad++;
         $display("FAIL R11 reset: got vld=%b res=%h flg=%b we=%b acc=%b, want all zero",
                  out_vld, res_o, flags_o, fwe_o, acc_we_o);
      end
   endtask

   task automatic t_add;
      apply("R1 nibble carry", ADD, 8'h0F, 8'h01, 4'h0, 8'h10, 4'b0010, 4'hF, 1'b1);
      apply("R1 R9 wrap to zero", ADD, 8'hFF, 8'h01, 4'h0, 8'h00, 4'b1011, 4'hF, 1'b1);
      apply("R1 adc carry into nibble", ADC, 8'h0E, 8'h01, 4'b0001, 8'h10, 4'b0010, 4'hF, 1'b1);
      apply("R1 adc carry ignored by add", ADD, 8'h0E, 8'h01, 4'b0001, 8'h0F, 4'b0000, 4'hF, 1'b1);
   endtask

   task automatic t_sub;
      apply("R2 nibble borrow", SUB, 8'h10, 8'h01, 4'h0, 8'h0F, 4'b0110, 4'hF, 1'b1);
      apply("R2 full borrow", SUB, 8'h00, 8'h01, 4'h0, 8'hFF, 4'b0111, 4'hF, 1'b1);
      apply("R2 sbc borrow in", SBC, 8'h05, 8'h05, 4'b0001, 8'hFF, 4'b0111, 4'hF, 1'b1);
      apply("R2 R9 equal", SUB, 8'h42, 8'h42, 4'h0, 8'h00, 4'b1100, 4'hF, 1'b1);
   endtask

   task automatic t_sweep;
      logic [7:0] r;
      logic [3:0] f;
      for (int i = 0; i < 24; i++) begin
         logic [7:0] a, b;
         bit ci;
         a  = 8'(i * 37 + 5);
         b  = 8'(i * 91 + 200);
         ci = i[0];
         ref_addsub(1'b0, a, b, ci, r, f);
         apply("R1 sweep adc", ADC, a, b, {3'b000, ci}, r, f, 4'hF, 1'b1);
         ref_addsub(1'b1, a, b, ci, r, f);
         apply("R2 sweep sbc", SBC, a, b, {3'b000, ci}, r, f, 4'hF, 1'b1);
      end
   endtask

   task automatic t_cp;
      apply("R3 R9 compare equal", CP, 8'h3C, 8'h3C, 4'h0, 8'h3C, 4'b1100, 4'hF, 1'b0);
      apply("R3 compare borrow", CP, 8'h20, 8'h31, 4'h0, 8'h20, 4'b0111, 4'hF, 1'b0);
   endtask

   task automatic t_logic;
      apply("R4 and zero", AND, 8'hF0, 8'h0F, 4'b0101, 8'h00, 4'b1010, 4'hF, 1'b1);
      apply("R4 xor", XOR, 8'h5A, 8'hA5, 4'b1111, 8'hFF, 4'b0000, 4'hF, 1'b1);
      apply("R4 R9 or zero", OR, 8'h00, 8'h00, 4'b0111, 8'h00, 4'b1000, 4'hF, 1'b1);
      apply("R4 or", OR, 8'h81, 8'h18, 4'h0, 8'h99, 4'b0000, 4'hF, 1'b1);
   endtask

   task automatic t_incdec;
      apply("R5 R12 inc wrap carry kept", INC, 8'hFF, 8'h00, 4'b0101, 8'h00, 4'b1011, 4'b1110, 1'b1);
      apply("R5 inc nibble", INC, 8'h0F, 8'h77, 4'b0100, 8'h10, 4'b0010, 4'b1110, 1'b1);
      apply("R5 dec nibble", DEC, 8'h10, 8'h00, 4'b1000, 8'h0F, 4'b0110, 4'b1110, 1'b1);
      apply("R5 R12 dec zero carry kept", DEC, 8'h01, 8'h00, 4'b0001, 8'h00, 4'b1101, 4'b1110, 1'b1);
   endtask

   task automatic t_cpl;
      apply("R6 R12 cpl keeps z c set", CPL, 8'h35, 8'h00, 4'b1001, 8'hCA, 4'b1111, 4'b0110, 1'b1);
      apply("R6 R12 cpl keeps z c clear", CPL, 8'hFF, 8'h12, 4'b0000, 8'h00, 4'b0110, 4'b0110, 1'b1);
   endtask

   task automatic t_daa;
      apply("R7 low digit fix", DAA, 8'h3C, 8'h00, 4'b0000, 8'h42, 4'b0000, 4'b1011, 1'b1);
      apply("R7 R9 both digits wrap", DAA, 8'h9A, 8'h00, 4'b0000, 8'h00, 4'b1001, 4'b1011, 1'b1);
      apply("R7 half carry fix", DAA, 8'h11, 8'h00, 4'b0010, 8'h17, 4'b0000, 4'b1011, 1'b1);
      apply("R7 carry in kept high", DAA, 8'h23, 8'h00, 4'b0001, 8'h83, 4'b0001, 4'b1011, 1'b1);
      apply("R8 sub low fix", DAA, 8'h0F, 8'h00, 4'b0110, 8'h09, 4'b0100, 4'b1011, 1'b1);
      apply("R8 sub both fix", DAA, 8'hFF, 8'h00, 4'b0111, 8'h99, 4'b0101, 4'b1011, 1'b1);
      apply("R8 sub no fix", DAA, 8'h45, 8'h00, 4'b0100, 8'h45, 4'b0100, 4'b1011, 1'b1);
   endtask

   task automatic t_unused;
      for (int k = 12; k < 16; k++) begin
         apply("R10 R12 unused code", 4'(k), 8'h6D, 8'h11, 4'(k - 5), 8'h6D, 4'(k - 5), 4'h0, 1'b0);
      end
   endtask

   task automatic t_idle;
      @(negedge clk);
      @(negedge clk);
      n_vec++;
      if (out_vld !== 1'b0 || res_o !== 8'h6D) begin
         n_bad++;
         $display("FAIL R11 idle: got vld=%b res=%h, want vld=0 res=6d", out_vld, res_o);
      end
   endtask

   initial begin
      #1;
      t_reset;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_add;
      t_sub;
      t_sweep;
      t_cp;
      t_logic;
      t_incdec;
      t_cpl;
      t_daa;
      t_unused;
      t_idle;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #50000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got hung run, want completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule